// File: doc/BRIEF.md
# Root Error Event Pulse Generator

This block sits in a root port and turns error events into a system-error alert. Devices lower in the hierarchy report errors in three classes: correctable, non-fatal and fatal. Each class reaches the block as a one-cycle message strobe. The block also watches a parameterised number of internal-error strobes. A class message raises the alert only when that class's enable bit in the root control register is set. Internal errors raise the alert whatever the enables hold. The alert leaves the block as a registered pulse, one clock wide for each cycle that carried a qualifying event.

Every event also sets a sticky bit in a status vector. This happens whether or not the alert fires, so an error whose class is disabled is still logged. Software-side logic clears status bits through a write-one-to-clear strobe vector. Message decoding, interrupt delivery and configuration access belong to other blocks.

Top module: `root_err_pulse_gen`

## Requirements
- R1: A synchronous active-low reset drives `sys_err_o` to 0 and every bit of `sts_o` to 0; both read 0 in the first cycle after the reset edge.
- R2: A correctable message (`msg_cor_i`) with `ctl_en_i[0]` set makes `sys_err_o` 1 in the cycle after the strobe.
- R3: Non-fatal (`msg_nonfatal_i`) and fatal (`msg_fatal_i`) messages raise `sys_err_o` in the following cycle only when `ctl_en_i[1]` or `ctl_en_i[2]` respectively is set. A message whose enable bit is clear leaves `sys_err_o` at 0.
- R4: Any set bit of `int_err_i` makes `sys_err_o` 1 in the following cycle, regardless of `ctl_en_i`.
- R5: Status bit positions are: bit 0 correctable, bit 1 non-fatal, bit 2 fatal, and bit 3+k internal source k. A bit becomes 1 in the cycle after its event, even when the class enable is clear.
- R6: A status bit stays 1 until a cycle with its `sts_clr_i` bit at 1, after which it reads 0. A `sts_clr_i` bit at 0 has no effect.
- R7: When a bit's set event and its clear strobe arrive in the same cycle, the bit reads 1 afterwards.
- R8: Qualifying events in back-to-back cycles give `sys_err_o` high in each following cycle. Several qualifying events in one cycle give a single high cycle.
- R9: `sys_err_o` is high for exactly one cycle per event cycle and returns to 0 in the next cycle unless a new qualifying event arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_cor_i | input | 1 | Correctable error message strobe |
| msg_nonfatal_i | input | 1 | Non-fatal error message strobe |
| msg_fatal_i | input | 1 | Fatal error message strobe |
| int_err_i | input | NUM_INT | Internal error strobes, one per source |
| ctl_en_i | input | 3 | Class alert enables: bit 0 correctable, bit 1 non-fatal, bit 2 fatal |
| sts_clr_i | input | 3+NUM_INT | Write-one-to-clear strobes for the status bits |
| sys_err_o | output | 1 | System-error pulse |
| sts_o | output | 3+NUM_INT | Sticky error source status |

## Verification
The bench builds the block with NUM_INT set to 3 and REG_OUT at 1. This gives a six-bit status vector, so clears, sets and set/clear collisions on the upper internal-source bits are exercised alongside the class bits. The registered pulse variant lets back-to-back events show up as adjacent high cycles that can be told apart from a single merged event. Random enable patterns reach every gating combination, including classes that are logged with their alert disabled.

// File: rtl/rerr_pkg.sv
package rerr_pkg;
   localparam int NUM_CLS = 3;

   typedef enum int {
      CLS_COR   = 0,
      CLS_NF    = 1,
      CLS_FATAL = 2
   } err_cls_e;

   function automatic int sts_width(input int num_int);
      return NUM_CLS + num_int;
   endfunction
endpackage

// File: rtl/rerr_gate.sv
module rerr_gate
   import rerr_pkg::*;
#(
   parameter int NUM_INT = 1,
   localparam int STS_W = sts_width(NUM_INT)
) (
   input  logic [NUM_CLS-1:0] msg_i,
   input  logic [NUM_CLS-1:0] en_i,
   input  logic [NUM_INT-1:0] int_i,
   output logic               trig_o,
   output logic [STS_W-1:0]   set_o
);
   logic [NUM_CLS-1:0] cls_hit;

   if (NUM_INT < 1) begin : g_bad_int
      $error("rerr_gate: NUM_INT must be at least 1");
   end

   for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
      assign cls_hit[c]  = msg_i[c] & en_i[c];
      assign set_o[c]    = msg_i[c];
   end

   for (genvar k = 0; k < NUM_INT; k++) begin : g_int
      assign set_o[NUM_CLS+k] = int_i[k];
   end

   assign trig_o = (|cls_hit) | (|int_i);
endmodule

// File: rtl/rerr_status.sv
module rerr_status #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] sts_o
);
   if (W < 1) begin : g_bad_w
      $error("rerr_status: W must be at least 1");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic q;
      always_ff @(posedge clk) begin
         if (!rst_n)        q <= 1'b0;
         else if (set_i[b]) q <= 1'b1;
         else if (clr_i[b]) q <= 1'b0;
      end
      assign sts_o[b] = q;

      assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[b] |=> sts_o[b]);
      assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (sts_o[b] && !clr_i[b]) |=> sts_o[b]);
      assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[b] && !set_i[b]) |=> !sts_o[b]);
      assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[b] && set_i[b]) |=> sts_o[b]);
   end

   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (sts_o == '0));
endmodule

// File: rtl/rerr_pulse.sv
module rerr_pulse #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   output logic pulse_o
);
   if (REG_OUT) begin : g_reg
      logic q;
      always_ff @(posedge clk) begin
         if (!rst_n) q <= 1'b0;
         else        q <= trig_i;
      end
      assign pulse_o = q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign pulse_o = trig_i;
   end
endmodule

// File: rtl/root_err_pulse_gen.sv
module root_err_pulse_gen
   import rerr_pkg::*;
#(
   parameter int NUM_INT = 1,
   parameter bit REG_OUT = 1'b1,
   localparam int STS_W = sts_width(NUM_INT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               msg_cor_i,
   input  logic               msg_nonfatal_i,
   input  logic               msg_fatal_i,
   input  logic [NUM_INT-1:0] int_err_i,
   input  logic [NUM_CLS-1:0] ctl_en_i,
   input  logic [STS_W-1:0]   sts_clr_i,
   output logic               sys_err_o,
   output logic [STS_W-1:0]   sts_o
);
   logic [NUM_CLS-1:0] msg_vec;
   logic               trig;
   logic [STS_W-1:0]   set_vec;

   if (NUM_INT < 1 || NUM_INT > 32) begin : g_bad_cfg
      $error("root_err_pulse_gen: NUM_INT must be in 1..32");
   end

   assign msg_vec[CLS_COR]   = msg_cor_i;
   assign msg_vec[CLS_NF]    = msg_nonfatal_i;
   assign msg_vec[CLS_FATAL] = msg_fatal_i;

   rerr_gate #(.NUM_INT(NUM_INT)) u_gate (
      .msg_i (msg_vec),
      .en_i  (ctl_en_i),
      .int_i (int_err_i),
      .trig_o(trig),
      .set_o (set_vec)
   );

   rerr_status #(.W(STS_W)) u_status (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(set_vec),
      .clr_i(sts_clr_i),
      .sts_o(sts_o)
   );

   rerr_pulse #(.REG_OUT(REG_OUT)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_i (trig),
      .pulse_o(sys_err_o)
   );

   if (REG_OUT) begin : g_pulse_chk
      assert_cor_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (msg_cor_i && ctl_en_i[0]) |=> sys_err_o);
      assert_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (!(msg_cor_i && ctl_en_i[0]) && !(msg_nonfatal_i && ctl_en_i[1])
          && !(msg_fatal_i && ctl_en_i[2]) && !(|int_err_i)) |=> !sys_err_o);
      assert_internal_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (|int_err_i) |=> sys_err_o);
      assert_fatal_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (msg_fatal_i && ctl_en_i[2]) |=> sys_err_o);
      assert_reset_pulse_R1: assert property (@(posedge clk)
         !rst_n |=> !sys_err_o);
   end
endmodule

// File: tb/root_err_pulse_gen_tb_top.sv
module root_err_pulse_gen_tb_top;
   localparam int NI = 3;
   localparam int SW = 3 + NI;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cor = 1'b0, nf = 1'b0, fat = 1'b0;
   logic [NI-1:0] ie = '0;
   logic [2:0]    en = '0;
   logic [SW-1:0] clr = '0;
   logic          sys_err;
   logic [SW-1:0] sts;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   logic          exp_p = 1'b0;
   logic [SW-1:0] exp_s = '0;

   always #4 clk = ~clk;

   root_err_pulse_gen #(.NUM_INT(NI), .REG_OUT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .msg_cor_i(cor), .msg_nonfatal_i(nf), .msg_fatal_i(fat),
      .int_err_i(ie), .ctl_en_i(en), .sts_clr_i(clr),
      .sys_err_o(sys_err), .sts_o(sts)
   );

   function automatic logic model_pulse(input logic c, input logic n, input logic f,
                                        input logic [NI-1:0] i, input logic [2:0] e);
      return (c & e[0]) | (n & e[1]) | (f & e[2]) | (|i);
   endfunction

   function automatic logic [SW-1:0] model_sts(input logic [SW-1:0] cur,
                                               input logic c, input logic n, input logic f,
                                               input logic [NI-1:0] i, input logic [SW-1:0] k);
      logic [SW-1:0] s;
      s = {i, f, n, c};
      return (cur & ~k) | s;
   endfunction

   task automatic check(input string rq);
      n_vec++;
      if (sys_err !== exp_p) begin
         n_bad++;
         $display("FAIL %s pulse got %b exp %b", rq, sys_err, exp_p);
      end
      n_vec++;
      if (sts !== exp_s) begin
         n_bad++;
         $display("FAIL %s status got %b exp %b", rq, sts, exp_s);
      end
   endtask

   // Called at a negedge: drive, let one posedge pass, check at next negedge.
   task automatic apply(input logic c, input logic n, input logic f,
                        input logic [NI-1:0] i, input logic [2:0] e,
                        input logic [SW-1:0] k, input string rq);
      cor = c; nf = n; fat = f; ie = i; en = e; clr = k;
      exp_p = model_pulse(c, n, f, i, e);
      exp_s = model_sts(exp_s, c, n, f, i, k);
      @(negedge clk);
      check(rq);
   endtask

   task automatic idle(input string rq);
      apply(1'b0, 1'b0, 1'b0, '0, en, '0, rq);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1");

      // R2: correctable enabled gives a pulse, then R9 drop
      apply(1'b1, 1'b0, 1'b0, '0, 3'b001, '0, "R2");
      idle("R9");
      // R3/R5: disabled non-fatal and fatal log without alert
      apply(1'b0, 1'b1, 1'b1, '0, 3'b001, '0, "R3");
      idle("R5");
      // R3: fatal enabled
      apply(1'b0, 1'b0, 1'b1, '0, 3'b100, '0, "R3");
      // R4: internal source 2 with all enables clear
      apply(1'b0, 1'b0, 1'b0, 3'b100, 3'b000, '0, "R4");
      idle("R9");
      // R6: zero clear has no effect, then clear bits 0 and 5
      apply(1'b0, 1'b0, 1'b0, '0, 3'b000, '0, "R6");
      apply(1'b0, 1'b0, 1'b0, '0, 3'b000, 6'b100001, "R6");
      // R7: set and clear of bit 1 together
      apply(1'b0, 1'b1, 1'b0, '0, 3'b000, 6'b000010, "R7");
      // R8: back-to-back events, then simultaneous events
      apply(1'b1, 1'b0, 1'b0, '0, 3'b111, '0, "R8");
      apply(1'b0, 1'b1, 1'b0, '0, 3'b111, '0, "R8");
      apply(1'b1, 1'b1, 1'b1, 3'b011, 3'b111, '0, "R8");
      idle("R9");
      // clear everything
      apply(1'b0, 1'b0, 1'b0, '0, 3'b111, '1, "R6");

      // R1: reset in the middle of activity
      apply(1'b1, 1'b0, 1'b1, 3'b001, 3'b111, '0, "R5");
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      exp_p = 1'b0; exp_s = '0;
      cor = 1'b0; nf = 1'b0; fat = 1'b0; ie = '0; clr = '0;
      @(negedge clk);
      check("R1");

      // Random phase
      for (int t = 0; t < 400; t++) begin
         logic c, n, f;
         logic [NI-1:0] i;
         logic [2:0] e;
         logic [SW-1:0] k;
         c = ($urandom_range(3) == 0);
         n = ($urandom_range(3) == 0);
         f = ($urandom_range(4) == 0);
         i = '0;
         for (int j = 0; j < NI; j++) i[j] = ($urandom_range(9) == 0);
         e = 3'($urandom_range(7));
         k = '0;
         for (int j = 0; j < SW; j++) k[j] = ($urandom_range(4) == 0);
         apply(c, n, f, i, e, k, "R8");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule